// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Unit

This block is the arithmetic and logic stage of an eight-bit accumulator machine. Each accepted request carries an operation code, the accumulator, an operand byte, two 16-bit register pairs for the wide add, the current five flags and a branch-condition select. One clock later the block presents the result byte, the 16-bit result, the next flags and the truth of the selected branch condition. The flags are an input here, and the caller owns the flag register.

Addition is split into two four-bit halves. The low half's carry-out becomes the auxiliary carry and feeds the high half. Subtraction feeds the ones complement of the operand into the same adder. The block also converts the five flags to and from the byte that is saved on the stack. A two-state controller runs the output stage. In `ST_IDLE` no result is valid. An accepted request moves it to `ST_HOLD` (transition "accept"). It stays in `ST_HOLD` while requests keep arriving ("chain"). It returns to `ST_IDLE` on the first cycle without a request ("drain").

Top module: `alu8_unit`

## Requirements
- R1: Flag buses use bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. Reset clears `out_valid` and all registered outputs. `out_valid` is high in the cycle after `in_valid` was sampled high, and low in the cycle after it was sampled low. Outputs change only on an accepted request.
- R2: ADD (op 0) and ADC (op 1, carry-in = carry flag) set auxiliary carry from the low-nibble carry-out and carry from the high-nibble carry-out.
- R3: SUB (op 2) and CMP (op 4) add the complemented operand with carry-in 1. SBB (op 3) uses the inverted carry flag as carry-in. Carry becomes the borrow, which is the inverted adder carry-out. Auxiliary carry is the raw low-nibble carry. CMP returns the accumulator unchanged.
- R4: For ops 0–9 and 17, sign is result bit 7, zero is set for a 0x00 result, and parity is set for an even count of one bits. CMP takes these flags from the difference.
- R5: AND (op 5), XOR (op 6) and OR (op 7) set sign, zero and parity from the result and clear carry and auxiliary carry.
- R6: INC (op 8) and DEC (op 9) operate on the accumulator, set auxiliary carry from the nibble adder, and leave carry unchanged.
- R7: RLC (op 10) and RRC (op 11) rotate circularly and copy the bit that wraps into carry. RAL (op 12) and RAR (op 13) rotate through carry. Only carry changes.
- R8: CMA (op 14) inverts the accumulator with flags unchanged. STC (op 15) sets carry. CMC (op 16) inverts carry. Codes 21 to 31 return the accumulator and leave the flags unchanged.
- R9: DAA (op 17) adds 0x06 if auxiliary carry is set or the low nibble is above 9. It then adds 0x60 if the carry flag or the first step's carry is set, or the high nibble is then above 9. Carry is the old carry ORed with both step carries. Auxiliary carry is 0 if the second step ran, else the first step's nibble carry, else unchanged.
- R10: DAD (op 18) returns `hl_in + pair_in` modulo 2^16 on `result16`. Carry is set when the true sum exceeds 0xFFFF, and the other four flags are unchanged. For every other op `result16` equals `hl_in`.
- R11: PACK (op 19) returns a byte with bit 7 sign, bit 6 zero, bit 4 auxiliary carry, bit 2 parity, bit 1 = 1, bit 0 carry, and bits 3 and 5 = 0. UNPACK (op 20) loads the flags from those bits of `operand`, ignores operand bits 1, 3 and 5, and returns the accumulator.
- R12: `cond_true` evaluates `cond_sel` against `flags_in`: 0 not-zero, 1 zero, 2 no-carry, 3 carry, 4 parity-odd, 5 parity-even, 6 plus, 7 minus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator |
| operand | input | 8 | Operand byte |
| hl_in | input | 16 | Base pair for the wide add |
| pair_in | input | 16 | Added pair for the wide add |
| flags_in | input | 5 | Current flags |
| cond_sel | input | 3 | Branch condition select |
| out_valid | output | 1 | Registered result valid |
| result | output | 8 | Result byte |
| result16 | output | 16 | Wide-add result |
| flags_out | output | 5 | Next flags |
| cond_true | output | 1 | Selected condition holds |

## Verification
The hardest case to reach is decimal adjust where the low-nibble correction itself carries, or pushes the high nibble above 9, so that the second correction is caused by the first. The stimulus reaches it with accumulator values chosen for this, such as 0x9B and 0xFA, alongside 0x99 and 0x00 with carry set. Borrow-through-subtract with a preset carry and unpack bytes that set only the ignored bit positions are driven the same way. A long pseudo-random run over all 32 codes then covers the rest.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned PAIR_W = 2 * DATA_W;

    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_ADC    = 5'd1,
        OP_SUB    = 5'd2,
        OP_SBB    = 5'd3,
        OP_CMP    = 5'd4,
        OP_AND    = 5'd5,
        OP_XOR    = 5'd6,
        OP_OR     = 5'd7,
        OP_INC    = 5'd8,
        OP_DEC    = 5'd9,
        OP_RLC    = 5'd10,
        OP_RRC    = 5'd11,
        OP_RAL    = 5'd12,
        OP_RAR    = 5'd13,
        OP_CMA    = 5'd14,
        OP_STC    = 5'd15,
        OP_CMC    = 5'd16,
        OP_DAA    = 5'd17,
        OP_DAD    = 5'd18,
        OP_PACK   = 5'd19,
        OP_UNPACK = 5'd20
    } alu_op_e;

    typedef struct packed {
        logic sgn;
        logic zer;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    localparam int unsigned FLAG_W = $bits(flags_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } stage_e;

    function automatic flags_t result_flags(input logic [DATA_W-1:0] r,
                                            input logic aux, input logic cry);
        flags_t f;
        f.sgn = r[DATA_W-1];
        f.zer = (r == '0);
        f.aux = aux;
        f.par = ~^r;
        f.cry = cry;
        return f;
    endfunction
endpackage

// File: rtl/alu8_nibble_adder.sv
module alu8_nibble_adder #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              invert_b,
    output logic [DATA_W-1:0] sum,
    output logic              half_cy,
    output logic              full_cy
);
    localparam int unsigned NIB_W  = DATA_W / 2;
    localparam int unsigned NIB_CT = DATA_W / NIB_W;

    logic [DATA_W-1:0] b_eff;
    logic [NIB_CT:0]   chain;

    assign b_eff    = invert_b ? ~b : b;
    assign chain[0] = cin;

    for (genvar g = 0; g < NIB_CT; g++) begin : g_nib
        assign {chain[g+1], sum[g*NIB_W +: NIB_W]} =
            {1'b0, a[g*NIB_W +: NIB_W]} + {1'b0, b_eff[g*NIB_W +: NIB_W]}
            + {{NIB_W{1'b0}}, chain[g]};
    end

    assign half_cy = chain[1];
    assign full_cy = chain[NIB_CT];
endmodule

// File: rtl/alu8_flag_port.sv
module alu8_flag_port
    import alu8_pkg::*;
(
    input  flags_t            cur,
    input  logic [DATA_W-1:0] byte_in,
    input  logic [2:0]        cond_sel,
    output logic [DATA_W-1:0] packed_byte,
    output flags_t            unpacked,
    output logic              cond_hit
);
    logic picked;

    always_comb begin
        packed_byte    = '0;
        packed_byte[7] = cur.sgn;
        packed_byte[6] = cur.zer;
        packed_byte[4] = cur.aux;
        packed_byte[2] = cur.par;
        packed_byte[1] = 1'b1;
        packed_byte[0] = cur.cry;
    end

    always_comb begin
        unpacked.sgn = byte_in[7];
        unpacked.zer = byte_in[6];
        unpacked.aux = byte_in[4];
        unpacked.par = byte_in[2];
        unpacked.cry = byte_in[0];
    end

    always_comb begin
        unique case (cond_sel[2:1])
            2'd0:    picked = cur.zer;
            2'd1:    picked = cur.cry;
            2'd2:    picked = cur.par;
            default: picked = cur.sgn;
        endcase
        cond_hit = cond_sel[0] ? picked : ~picked;
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    input  logic [PAIR_W-1:0] hl_in,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [2:0]        cond_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [PAIR_W-1:0] result16,
    output logic [FLAG_W-1:0] flags_out,
    output logic              cond_true
);
    flags_t  f_in;
    alu_op_e op_e;
    stage_e  state_q, state_d;

    assign f_in = flags_t'(flags_in);
    assign op_e = alu_op_e'(op);

    // main nibble adder
    logic [DATA_W-1:0] add_b, add_sum;
    logic              add_cin, add_inv, add_hc, add_cy;

    always_comb begin
        add_b   = operand;
        add_cin = 1'b0;
        add_inv = 1'b0;
        unique case (op_e)
            OP_ADC: add_cin = f_in.cry;
            OP_SUB, OP_CMP: begin
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            OP_SBB: begin
                add_inv = 1'b1;
                add_cin = ~f_in.cry;
            end
            OP_INC: add_b = DATA_W'(1);
            OP_DEC: begin
                add_b   = DATA_W'(1);
                add_inv = 1'b1;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_nibble_adder #(.DATA_W(DATA_W)) u_main_add (
        .a(acc_in), .b(add_b), .cin(add_cin), .invert_b(add_inv),
        .sum(add_sum), .half_cy(add_hc), .full_cy(add_cy)
    );

    // decimal adjust: two chained corrections
    logic [DATA_W-1:0] lo_sum, mid, hi_sum, daa_res;
    logic              lo_fix, lo_hc, lo_cy, mid_cy, hi_fix, hi_hc, hi_cy;
    logic              daa_aux, daa_cy;

    assign lo_fix = f_in.aux | (acc_in[3:0] > 4'd9);

    alu8_nibble_adder #(.DATA_W(DATA_W)) u_daa_lo (
        .a(acc_in), .b(8'h06), .cin(1'b0), .invert_b(1'b0),
        .sum(lo_sum), .half_cy(lo_hc), .full_cy(lo_cy)
    );

    assign mid    = lo_fix ? lo_sum : acc_in;
    assign mid_cy = f_in.cry | (lo_fix & lo_cy);
    assign hi_fix = mid_cy | (mid[7:4] > 4'd9);

    alu8_nibble_adder #(.DATA_W(DATA_W)) u_daa_hi (
        .a(mid), .b(8'h60), .cin(1'b0), .invert_b(1'b0),
        .sum(hi_sum), .half_cy(hi_hc), .full_cy(hi_cy)
    );

    assign daa_res = hi_fix ? hi_sum : mid;
    assign daa_aux = hi_fix ? hi_hc : (lo_fix ? lo_hc : f_in.aux);
    assign daa_cy  = mid_cy | (hi_fix & hi_cy);

    // wide pair add
    logic [PAIR_W:0] dad_sum;
    assign dad_sum = {1'b0, hl_in} + {1'b0, pair_in};

    // flag byte conversion and branch conditions
    logic [DATA_W-1:0] pack_byte;
    flags_t            unpack_f;
    logic              cond_hit;

    alu8_flag_port u_flag_port (
        .cur(f_in), .byte_in(operand), .cond_sel(cond_sel),
        .packed_byte(pack_byte), .unpacked(unpack_f), .cond_hit(cond_hit)
    );

    // result selection
    logic [DATA_W-1:0] nx_res;
    logic [PAIR_W-1:0] nx_r16;
    flags_t            nx_flags;

    always_comb begin
        nx_res   = acc_in;
        nx_r16   = hl_in;
        nx_flags = f_in;
        unique case (op_e)
            OP_ADD, OP_ADC: begin
                nx_res   = add_sum;
                nx_flags = result_flags(add_sum, add_hc, add_cy);
            end
            OP_SUB, OP_SBB: begin
                nx_res   = add_sum;
                nx_flags = result_flags(add_sum, add_hc, ~add_cy);
            end
            OP_CMP: nx_flags = result_flags(add_sum, add_hc, ~add_cy);
            OP_AND: begin
                nx_res   = acc_in & operand;
                nx_flags = result_flags(acc_in & operand, 1'b0, 1'b0);
            end
            OP_XOR: begin
                nx_res   = acc_in ^ operand;
                nx_flags = result_flags(acc_in ^ operand, 1'b0, 1'b0);
            end
            OP_OR: begin
                nx_res   = acc_in | operand;
                nx_flags = result_flags(acc_in | operand, 1'b0, 1'b0);
            end
            OP_INC, OP_DEC: begin
                nx_res   = add_sum;
                nx_flags = result_flags(add_sum, add_hc, f_in.cry);
            end
            OP_RLC: begin
                nx_res       = {acc_in[DATA_W-2:0], acc_in[DATA_W-1]};
                nx_flags.cry = acc_in[DATA_W-1];
            end
            OP_RRC: begin
                nx_res       = {acc_in[0], acc_in[DATA_W-1:1]};
                nx_flags.cry = acc_in[0];
            end
            OP_RAL: begin
                nx_res       = {acc_in[DATA_W-2:0], f_in.cry};
                nx_flags.cry = acc_in[DATA_W-1];
            end
            OP_RAR: begin
                nx_res       = {f_in.cry, acc_in[DATA_W-1:1]};
                nx_flags.cry = acc_in[0];
            end
            OP_CMA: nx_res = ~acc_in;
            OP_STC: nx_flags.cry = 1'b1;
            OP_CMC: nx_flags.cry = ~f_in.cry;
            OP_DAA: begin
                nx_res   = daa_res;
                nx_flags = result_flags(daa_res, daa_aux, daa_cy);
            end
            OP_DAD: begin
                nx_r16       = dad_sum[PAIR_W-1:0];
                nx_flags.cry = dad_sum[PAIR_W];
            end
            OP_PACK:   nx_res = pack_byte;
            OP_UNPACK: nx_flags = unpack_f;
            default: ;
        endcase
    end

    // controller: state register
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            result16  <= '0;
            flags_out <= '0;
            cond_true <= 1'b0;
        end else if (in_valid) begin
            result    <= nx_res;
            result16  <= nx_r16;
            flags_out <= nx_flags;
            cond_true <= cond_hit;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    // assertions
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_zero_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op <= 5'd9) && (op != 5'd4) |=> flags_out[3] == (result == '0));
    assert_logic_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op >= 5'd5) && (op <= 5'd7) |=> !flags_out[2] && !flags_out[0]);
    assert_incdec_keep_cy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 5'd8 || op == 5'd9) |=> flags_out[0] == $past(flags_in[0]));
    assert_daa_cy_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 5'd17) && flags_in[0] |=> flags_out[0]);
    assert_dad_only_cy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 5'd18) |=> flags_out[4:1] == $past(flags_in[4:1]));
    assert_pack_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 5'd19) |=> result[1] && !result[3] && !result[5]);
endmodule

// File: tb/alu8_unit_bench.sv
`timescale 1ns/1ps
module alu8_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [7:0]  acc_in = '0, operand = '0;
    logic [15:0] hl_in = '0, pair_in = '0;
    logic [4:0]  flags_in = '0;
    logic [2:0]  cond_sel = '0;
    logic        out_valid, cond_true;
    logic [7:0]  result;
    logic [15:0] result16;
    logic [4:0]  flags_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    alu8_unit u_alu8_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .acc_in(acc_in), .operand(operand), .hl_in(hl_in), .pair_in(pair_in),
        .flags_in(flags_in), .cond_sel(cond_sel), .out_valid(out_valid),
        .result(result), .result16(result16), .flags_out(flags_out),
        .cond_true(cond_true)
    );

    function automatic int szp(int r, int ac, int cy);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (r >> i) & 1;
        return (((r >> 7) & 1) << 4) | ((r == 0) << 3) | (ac << 2) | (((n % 2) == 0) << 1) | cy;
    endfunction

    task automatic model(input int o, a, b, fl, hl, pr, cs,
                         output int r, r16, fo, ct);
        int cy = fl & 1, p = (fl >> 1) & 1, ac = (fl >> 2) & 1;
        int z = (fl >> 3) & 1, s = (fl >> 4) & 1;
        int sum, bb, cin, t, c1, h;
        int fix1, fix2, pick;
        r = a; r16 = hl; fo = fl;
        case (o)
            0, 1: begin
                cin = (o == 1) ? cy : 0;
                sum = a + b + cin;
                r = sum & 255;
                fo = szp(r, ((a & 15) + (b & 15) + cin) > 15, sum > 255);
            end
            2, 3, 4: begin
                bb = (~b) & 255;
                cin = (o == 3) ? 1 - cy : 1;
                sum = a + bb + cin;
                fo = szp(sum & 255, ((a & 15) + (bb & 15) + cin) > 15, !(sum > 255));
                if (o != 4) r = sum & 255;
            end
            5: begin r = a & b; fo = szp(r, 0, 0); end
            6: begin r = a ^ b; fo = szp(r, 0, 0); end
            7: begin r = a | b; fo = szp(r, 0, 0); end
            8: begin r = (a + 1) & 255; fo = szp(r, ((a & 15) + 1) > 15, cy); end
            9: begin r = (a + 254 + 1) & 255; fo = szp(r, ((a & 15) + 14 + 1) > 15, cy); end
            10: begin r = ((a << 1) | (a >> 7)) & 255; fo = (fl & 30) | (a >> 7); end
            11: begin r = (a >> 1) | ((a & 1) << 7); fo = (fl & 30) | (a & 1); end
            12: begin r = ((a << 1) | cy) & 255; fo = (fl & 30) | (a >> 7); end
            13: begin r = (a >> 1) | (cy << 7); fo = (fl & 30) | (a & 1); end
            14: r = (~a) & 255;
            15: fo = fl | 1;
            16: fo = fl ^ 1;
            17: begin
                t = a; c1 = 0; h = ac;
                fix1 = ac || ((a & 15) > 9);
                if (fix1) begin
                    h = ((t & 15) + 6) > 15;
                    c1 = (t + 6) > 255;
                    t = (t + 6) & 255;
                end
                fix2 = cy || c1 || ((t >> 4) > 9);
                if (fix2) begin
                    if ((t + 96) > 255) c1 = 1;
                    t = (t + 96) & 255;
                    h = 0;
                end
                r = t;
                fo = szp(t, h, cy | c1);
            end
            18: begin
                sum = hl + pr;
                r16 = sum & 65535;
                fo = (fl & 30) | (sum > 65535);
            end
            19: r = (s << 7) | (z << 6) | (ac << 4) | (p << 2) | 2 | cy;
            20: fo = (((b >> 7) & 1) << 4) | (((b >> 6) & 1) << 3) | (((b >> 4) & 1) << 2)
                     | (((b >> 2) & 1) << 1) | (b & 1);
            default: ;
        endcase
        case (cs >> 1)
            0: pick = z;
            1: pick = cy;
            2: pick = p;
            default: pick = s;
        endcase
        ct = (cs & 1) ? pick : 1 - pick;
    endtask

    task automatic do_op(input int o, a, b, fl, hl, pr, cs, input string tag);
        int er, e16, ef, ec;
        op = o[4:0]; acc_in = a[7:0]; operand = b[7:0]; flags_in = fl[4:0];
        hl_in = hl[15:0]; pair_in = pr[15:0]; cond_sel = cs[2:0]; in_valid = 1'b1;
        model(o, a, b, fl, hl, pr, cs, er, e16, ef, ec);
        @(negedge clk);
        checks++;
        if (!out_valid || result !== er[7:0] || result16 !== e16[15:0]
            || flags_out !== ef[4:0] || cond_true !== ec[0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h f=%h: got v=%b r=%h r16=%h f=%h c=%b exp v=1 r=%h r16=%h f=%h c=%0d",
                     tag, o, a, b, fl, out_valid, result, result16, flags_out, cond_true,
                     er[7:0], e16[15:0], ef[4:0], ec);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog R1: got hung run exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00 || flags_out !== 5'h00 || result16 !== 16'h0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b r=%h f=%h exp v=0 r=00 f=00", out_valid, result, flags_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 8'h0F, 8'h01, 0, 0, 0, 0, "R2");
        do_op(0, 8'hFF, 8'h01, 0, 0, 0, 1, "R2");
        do_op(1, 8'h7F, 8'h00, 1, 0, 0, 2, "R2");
        do_op(2, 8'h10, 8'h01, 0, 0, 0, 3, "R3");
        do_op(2, 8'h00, 8'h01, 0, 0, 0, 3, "R3");
        do_op(3, 8'h05, 8'h05, 1, 0, 0, 0, "R3");
        do_op(4, 8'h42, 8'h42, 0, 0, 0, 1, "R3");
        do_op(4, 8'h03, 8'h07, 0, 0, 0, 4, "R4");
        do_op(5, 8'hF0, 8'h3C, 5'h1F, 0, 0, 5, "R5");
        do_op(6, 8'hAA, 8'hAA, 5'h1F, 0, 0, 6, "R5");
        do_op(7, 8'h81, 8'h02, 5'h1F, 0, 0, 7, "R5");
        do_op(8, 8'hFF, 8'h00, 0, 0, 0, 0, "R6");
        do_op(9, 8'h00, 8'h00, 1, 0, 0, 0, "R6");
        do_op(9, 8'h10, 8'h00, 0, 0, 0, 0, "R6");
        do_op(10, 8'h81, 0, 0, 0, 0, 0, "R7");
        do_op(11, 8'h81, 0, 5'h1E, 0, 0, 0, "R7");
        do_op(12, 8'h01, 0, 1, 0, 0, 0, "R7");
        do_op(13, 8'h80, 0, 1, 0, 0, 0, "R7");
        do_op(14, 8'h5A, 0, 5'h15, 0, 0, 0, "R8");
        do_op(15, 0, 0, 5'h10, 0, 0, 0, "R8");
        do_op(16, 0, 0, 5'h11, 0, 0, 0, "R8");
        do_op(25, 8'h33, 8'h44, 5'h0A, 0, 0, 0, "R8");
        do_op(17, 8'h9B, 0, 0, 0, 0, 0, "R9");
        do_op(17, 8'hFA, 0, 0, 0, 0, 0, "R9");
        do_op(17, 8'h15, 0, 5'h04, 0, 0, 0, "R9");
        do_op(17, 8'h99, 0, 0, 0, 0, 0, "R9");
        do_op(17, 8'h00, 0, 1, 0, 0, 0, "R9");
        do_op(18, 0, 0, 5'h1E, 16'hFFFF, 16'h0001, 0, "R10");
        do_op(18, 0, 0, 5'h01, 16'h1234, 16'h1111, 0, "R10");
        do_op(19, 8'h12, 0, 5'h1F, 0, 0, 0, "R11");
        do_op(19, 8'h12, 0, 5'h00, 0, 0, 0, "R11");
        do_op(20, 8'h77, 8'h2A, 5'h1F, 0, 0, 0, "R11");
        do_op(20, 8'h77, 8'hFF, 5'h00, 0, 0, 0, "R11");
        for (int c = 0; c < 8; c++) begin
            do_op(5'd24, 0, 0, 5'h00, 0, 0, c, "R12");
            do_op(5'd24, 0, 0, 5'h1F, 0, 0, c, "R12");
            do_op(5'd24, 0, 0, 5'h0A, 0, 0, c, "R12");
        end

        for (int i = 0; i < 600; i++) begin
            do_op(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 31)),
                  int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 7)), "R4");
        end

        held = result;
        in_valid = 1'b0;
        acc_in = 8'hC3;
        op = 5'd14;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held) begin
            fails++;
            $display("FAIL R1 idle: got v=%b r=%h exp v=0 r=%h", out_valid, result, held);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule